// File: doc/BRIEF.md
# Tuner Configuration I2C Register File

This block is an I2C target that gives a host controller access to a small file of sixteen 8-bit registers, which set up an FM receiver front end. The system clock oversamples SCL and SDA through a two-stage synchroniser. Edge and condition detectors feed a byte-level control FSM. A datapath holds the receive and transmit shift registers, the register pointer and the storage. SDA is never driven high. The block only asserts a pull-down enable, and the pad and pull-up turn that into a wired-AND bus. The bus runs at standard or fast speed. The target never holds SCL low, so there is no clock stretching.

A transaction begins with the fixed 7-bit device address. For a write, a register-pointer byte follows and then any number of data bytes. Each data byte goes into the pointed register, and the pointer then advances. A read first sets the pointer with a write, then issues a repeated START with the read direction. The target returns bytes from the pointer onward, and the pointer moves only when the host acknowledges.

Two register slots are read-only windows onto status inputs: the IF count result and the signal-strength code. One bit of register 1 starts a measurement. It clears itself when the measuring logic reports completion. All writable bytes appear together on a flat control bus.

Top module: `tuner_i2c_regfile`

## Requirements
- R1: After reset, sdaOe is low and every byte of ctrlRegs is 0x00.
- R2: The target acknowledges only the device byte whose upper seven bits are 1110010 (bit 0 is the direction: 0 write, 1 read). For any other address it releases SDA and ignores the rest of the transaction until the next START, and no register changes.
- R3: In the register-pointer byte only bits 3:0 select the register. Bits 7:4 are ignored.
- R4: In a write, bytes arrive MSB first, each data byte is acknowledged, and byte k lands in register (pointer + k) mod 16, wrapping from 15 to 0.
- R5: In a read, the target shifts out the pointed register MSB first. A host ACK advances the pointer by one and fetches the next byte. A host NACK leaves the pointer in place and releases SDA, so a later read with no pointer byte returns the same register.
- R6: Register 3 reads back ifCountIn and register 15 reads back rssiIn. Writes to either are acknowledged but change nothing, and their bytes on ctrlRegs stay 0x00.
- R7: A one-cycle pulse on measDoneIn clears bit 1 of register 1 and leaves its other bits unchanged.
- R8: When a bus write to register 1 and a measDoneIn pulse fall in the same clock cycle, the written value of bit 1 is kept.
- R9: A START or STOP at any point abandons the transfer in progress. A partly received byte is not written, and SDA is released in the cycle after the condition is detected.
- R10: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL level from the pad |
| sdaIn | input | 1 | SDA level from the pad |
| sdaOe | output | 1 | High pulls SDA low (open-drain enable) |
| measDoneIn | input | 1 | Measurement-complete pulse; clears the start bit |
| ifCountIn | input | 8 | IF count status, read at register 3 |
| rssiIn | input | 8 | Signal-strength status, read at register 15 |
| ctrlRegs | output | 128 | Writable registers, register n at bits 8n+7:8n |

## Verification
The two functions that can meet in one cycle are the bus write of register 1 and the hardware clear of its start bit. The bench provokes the overlap by counting the synchroniser stages from the SCL fall that closes the data acknowledge, then pulsing measDoneIn in exactly the cycle that carries the write strobe. The outcome passes only if the freshly written bit survives. A lone pulse, judged separately, must clear just that bit. Random bursts with random register-pointer bytes and random status inputs cover pointer wrap and reads through the read-only windows around those directed cases.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_DEVACK,
    ST_REGADDR,
    ST_REGACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } busState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftRx;
    logic setPtr;
    logic incPtr;
    logic wrReg;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;

endpackage

// File: rtl/tuner_i2c_sync.sv
// Bus synchroniser and condition detector. STAGES must be 2 or more.
module tuner_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclD;
  logic sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclD    <= sclLvl;
      sdaD    <= sdaLvl;
    end
  end

  assign sclLvl   = sclPipe[STAGES-1];
  assign sdaLvl   = sdaPipe[STAGES-1];
  assign sclRise  = sclLvl & ~sclD;
  assign sclFall  = ~sclLvl & sclD;
  assign startDet = sclLvl & sclD & sdaD & ~sdaLvl;
  assign stopDet  = sclLvl & sclD & ~sdaD & sdaLvl;

endmodule

// File: rtl/tuner_i2c_ctrl.sv
module tuner_i2c_ctrl
  import tuner_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1110010
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startDet,
  input  logic             stopDet,
  input  logic             sdaLvl,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic             txBit,
  output dpStrobe_t        strobe,
  output logic             sdaOe
);

  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  busState_t state, stNext;
  logic [3:0] bitCnt, cntNext;
  logic readMode, rdNext;
  logic masterAck, mackNext;

  always_comb begin
    stNext   = state;
    cntNext  = bitCnt;
    rdNext   = readMode;
    mackNext = masterAck;
    strobe   = '0;
    if (startDet) begin
      stNext  = ST_DEVADDR;
      cntNext = '0;
    end else if (stopDet) begin
      stNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_DEVADDR, ST_REGADDR, ST_WDATA: begin
          if (sclRise && bitCnt != LAST_BIT) begin
            strobe.shiftRx = 1'b1;
            cntNext = bitCnt + 4'd1;
          end
          if (sclFall && bitCnt == LAST_BIT) begin
            cntNext = '0;
            if (state == ST_DEVADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                stNext = ST_DEVACK;
                rdNext = rxByte[0];
              end else begin
                stNext = ST_IDLE;
              end
            end else if (state == ST_REGADDR) begin
              strobe.setPtr = 1'b1;
              stNext = ST_REGACK;
            end else begin
              stNext = ST_WACK;
            end
          end
        end
        ST_DEVACK: begin
          if (sclFall) begin
            if (readMode) begin
              strobe.loadTx = 1'b1;
              stNext = ST_RDATA;
            end else begin
              stNext = ST_REGADDR;
            end
          end
        end
        ST_REGACK: begin
          if (sclFall) stNext = ST_WDATA;
        end
        ST_WACK: begin
          if (sclFall) begin
            strobe.wrReg  = 1'b1;
            strobe.incPtr = 1'b1;
            stNext = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise && bitCnt != LAST_BIT) cntNext = bitCnt + 4'd1;
          if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              cntNext = '0;
              stNext = ST_RACK;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) mackNext = ~sdaLvl;
          if (sclFall) begin
            if (masterAck) begin
              strobe.incPtr = 1'b1;
              strobe.loadTx = 1'b1;
              stNext = ST_RDATA;
            end else begin
              stNext = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stNext;
      bitCnt    <= cntNext;
      readMode  <= rdNext;
      masterAck <= mackNext;
    end
  end

  logic ackDrive;
  assign ackDrive = (state == ST_DEVACK) || (state == ST_REGACK) || (state == ST_WACK);
  assign sdaOe    = ackDrive || ((state == ST_RDATA) && !txBit);

endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
  import tuner_i2c_pkg::*;
#(
  parameter int NUM_REGS      = 16,
  parameter int IFC_ADDR      = 3,
  parameter int RSSI_ADDR     = 15,
  parameter int SELF_CLR_ADDR = 1,
  parameter int SELF_CLR_BIT  = 1,
  parameter logic [NUM_REGS*BYTE_W-1:0] RESET_IMAGE = '0,
  localparam int PTR_W = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic                       sdaLvl,
  input  logic                       measDoneIn,
  input  logic [BYTE_W-1:0]          ifCountIn,
  input  logic [BYTE_W-1:0]          rssiIn,
  output logic [BYTE_W-1:0]          rxByte,
  output logic                       txBit,
  output logic [PTR_W-1:0]           ptr,
  output logic [NUM_REGS*BYTE_W-1:0] ctrlRegs
);

  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic [NUM_REGS-1:0][BYTE_W-1:0] readVal;
  logic [PTR_W-1:0] loadAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      ptr     <= '0;
    end else begin
      if (strobe.shiftRx) rxShift <= {rxShift[BYTE_W-2:0], sdaLvl};
      if (strobe.setPtr) ptr <= rxShift[PTR_W-1:0];
      else if (strobe.incPtr) ptr <= ptr + 1'b1;
      if (strobe.loadTx) txShift <= readVal[loadAddr];
      else if (strobe.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  // fetch ahead of the pointer when it advances in the same cycle
  assign loadAddr = strobe.incPtr ? ptr + 1'b1 : ptr;
  assign rxByte   = rxShift;
  assign txBit    = txShift[BYTE_W-1];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    if (i == IFC_ADDR) begin : g_ifc
      assign readVal[i] = ifCountIn;
      assign ctrlRegs[i*BYTE_W +: BYTE_W] = '0;
    end else if (i == RSSI_ADDR) begin : g_rssi
      assign readVal[i] = rssiIn;
      assign ctrlRegs[i*BYTE_W +: BYTE_W] = '0;
    end else begin : g_rw
      logic [BYTE_W-1:0] store;
      logic wrHit;
      assign wrHit = strobe.wrReg && (ptr == PTR_W'(i));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) store <= RESET_IMAGE[i*BYTE_W +: BYTE_W];
        else if (wrHit) store <= rxShift;
        else if ((i == SELF_CLR_ADDR) && measDoneIn) store[SELF_CLR_BIT] <= 1'b0;
      end
      assign readVal[i] = store;
      assign ctrlRegs[i*BYTE_W +: BYTE_W] = store;
    end
  end

endmodule

// File: rtl/tuner_i2c_regfile.sv
module tuner_i2c_regfile
  import tuner_i2c_pkg::*;
#(
  parameter int NUM_REGS      = 16,
  parameter logic [6:0] DEV_ADDR = 7'b1110010,
  parameter int IFC_ADDR      = 3,
  parameter int RSSI_ADDR     = 15,
  parameter int SELF_CLR_ADDR = 1,
  parameter int SELF_CLR_BIT  = 1,
  parameter int SYNC_STAGES   = 2,
  parameter logic [NUM_REGS*8-1:0] RESET_IMAGE = '0,
  localparam int PTR_W = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sdaOe,
  input  logic                 measDoneIn,
  input  logic [7:0]           ifCountIn,
  input  logic [7:0]           rssiIn,
  output logic [NUM_REGS*8-1:0] ctrlRegs
);

  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [7:0] rxByte;
  logic txBit;
  logic [PTR_W-1:0] ptr;
  dpStrobe_t strobe;

  tuner_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  tuner_i2c_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .txBit(txBit), .strobe(strobe), .sdaOe(sdaOe)
  );

  tuner_i2c_regs #(
    .NUM_REGS(NUM_REGS), .IFC_ADDR(IFC_ADDR), .RSSI_ADDR(RSSI_ADDR),
    .SELF_CLR_ADDR(SELF_CLR_ADDR), .SELF_CLR_BIT(SELF_CLR_BIT),
    .RESET_IMAGE(RESET_IMAGE)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaLvl(sdaLvl),
    .measDoneIn(measDoneIn), .ifCountIn(ifCountIn), .rssiIn(rssiIn),
    .rxByte(rxByte), .txBit(txBit), .ptr(ptr), .ctrlRegs(ctrlRegs)
  );

endmodule

// File: rtl/tuner_i2c_chk.sv
module tuner_i2c_chk #(
  parameter int NUM_REGS      = 16,
  parameter int PTR_W         = 4,
  parameter int SELF_CLR_ADDR = 1,
  parameter int SELF_CLR_BIT  = 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclLvl,
  input logic                  startDet,
  input logic                  stopDet,
  input logic                  sdaOe,
  input logic                  measDoneIn,
  input logic                  wrReg,
  input logic                  setPtr,
  input logic                  incPtr,
  input logic [PTR_W-1:0]      ptr,
  input logic [7:0]            rxByte,
  input logic [NUM_REGS*8-1:0] ctrlRegs
);

  localparam int SC_IDX = SELF_CLR_ADDR * 8 + SELF_CLR_BIT;

  // R10
  sda_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLvl);

  // R9
  release_on_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startDet || stopDet) |=> !sdaOe);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incPtr && !setPtr) |=> (ptr == $past(ptr) + 1'b1));

  // R7
  self_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (measDoneIn && !(wrReg && ptr == PTR_W'(SELF_CLR_ADDR))) |=> !ctrlRegs[SC_IDX]);

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (measDoneIn && wrReg && ptr == PTR_W'(SELF_CLR_ADDR))
      |=> (ctrlRegs[SC_IDX] == $past(rxByte[SELF_CLR_BIT])));

endmodule

bind tuner_i2c_regfile tuner_i2c_chk #(
  .NUM_REGS(NUM_REGS), .PTR_W(PTR_W),
  .SELF_CLR_ADDR(SELF_CLR_ADDR), .SELF_CLR_BIT(SELF_CLR_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .startDet(startDet),
  .stopDet(stopDet), .sdaOe(sdaOe), .measDoneIn(measDoneIn),
  .wrReg(strobe.wrReg), .setPtr(strobe.setPtr), .incPtr(strobe.incPtr),
  .ptr(ptr), .rxByte(rxByte), .ctrlRegs(ctrlRegs)
);

// File: tb/tuner_i2c_regfile_bench.sv
module tuner_i2c_regfile_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam logic [7:0] ADDR_W = 8'hE4;
  localparam logic [7:0] ADDR_R = 8'hE5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic measDoneIn = 1'b0;
  logic [7:0] ifCountIn = 8'h5A;
  logic [7:0] rssiIn = 8'hC3;
  logic sdaIn;
  logic sdaOe;
  logic [127:0] ctrlRegs;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaIn = mSda & ~sdaOe;

  tuner_i2c_regfile u_tuner_i2c_regfile (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaIn), .sdaOe(sdaOe),
    .measDoneIn(measDoneIn), .ifCountIn(ifCountIn), .rssiIn(rssiIn),
    .ctrlRegs(ctrlRegs)
  );

  int checks = 0;
  int errors = 0;
  int oeFlips = 0;
  bit finished = 1'b0;
  logic prevOe = 1'b0;
  logic [7:0] model [16];
  logic [7:0] wbuf [16];
  logic [3:0] ptrModel = '0;

  // R10 monitor: drive changes while SCL is high
  always @(negedge clk) begin
    if (rstN && (sdaOe !== prevOe) && mScl) oeFlips++;
    prevOe = sdaOe;
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit writable(input logic [3:0] a);
    return !(a == 4'd3 || a == 4'd15);
  endfunction

  function automatic logic [7:0] expRead(input logic [3:0] a);
    if (a == 4'd3) return ifCountIn;
    if (a == 4'd15) return rssiIn;
    return model[a];
  endfunction

  function automatic logic [127:0] expFlat();
    logic [127:0] r;
    for (int a = 0; a < 16; a++) r[a*8 +: 8] = writable(4'(a)) ? model[a] : 8'h00;
    return r;
  endfunction

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      mSda = b[i]; waitQ();
      mScl = 1'b1; waitQ(); waitQ();
      mScl = 1'b0; waitQ();
    end
  endtask

  // pulse: raise measDoneIn in the cycle the target commits this byte
  task automatic sendByte(input logic [7:0] b, input bit pulse, output bit ack);
    sendBits(b, 8);
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    ack = !sdaIn; waitQ();
    mScl = 1'b0;
    if (pulse) begin
      repeat (2) @(negedge clk);
      measDoneIn = 1'b1;
      @(negedge clk);
      measDoneIn = 1'b0;
      repeat (Q - 3) @(negedge clk);
    end else begin
      waitQ();
    end
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      mSda = 1'b1; waitQ();
      mScl = 1'b1; waitQ();
      b = {b[6:0], sdaIn}; waitQ();
      mScl = 1'b0; waitQ();
    end
    mSda = !giveAck; waitQ();
    mScl = 1'b1; waitQ(); waitQ();
    mScl = 1'b0; waitQ();
    mSda = 1'b1;
  endtask

  task automatic doWrite(input logic [7:0] regByte, input int n, input int pulseIdx);
    bit ack;
    i2cStart();
    sendByte(ADDR_W, 1'b0, ack);
    chk("R2 device address ack", 128'(ack), 128'd1);
    sendByte(regByte, 1'b0, ack);
    chk("R3 register byte ack", 128'(ack), 128'd1);
    ptrModel = regByte[3:0];
    for (int k = 0; k < n; k++) begin
      sendByte(wbuf[k], k == pulseIdx, ack);
      chk("R4 data byte ack", 128'(ack), 128'd1);
      if (writable(ptrModel)) model[ptrModel] = wbuf[k];
      ptrModel = ptrModel + 4'd1;
    end
    i2cStop();
  endtask

  task automatic doRead(input bit setReg, input logic [7:0] regByte, input int n, input string tag);
    bit ack;
    logic [7:0] d;
    i2cStart();
    if (setReg) begin
      sendByte(ADDR_W, 1'b0, ack);
      chk("R2 device address ack", 128'(ack), 128'd1);
      sendByte(regByte, 1'b0, ack);
      ptrModel = regByte[3:0];
      i2cStart();
    end
    sendByte(ADDR_R, 1'b0, ack);
    chk("R2 read address ack", 128'(ack), 128'd1);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, d);
      chk(tag, 128'(d), 128'(expRead(ptrModel)));
      if (k < n - 1) ptrModel = ptrModel + 4'd1;
    end
    i2cStop();
  endtask

  initial begin
    bit ack;
    int n;
    logic [7:0] rb;
    for (int a = 0; a < 16; a++) model[a] = 8'h00;
    void'($urandom(32'h1a2b3c));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 sdaOe after reset", 128'(sdaOe), 128'd0);
    chk("R1 control bus after reset", ctrlRegs, 128'd0);
    doRead(1'b1, 8'h00, 1, "R1 reset readback");

    // R3 upper nibble ignored
    wbuf[0] = 8'hA5;
    doWrite(8'hF5, 1, -1);
    chk("R3 upper nibble ignored", ctrlRegs, expFlat());
    doRead(1'b1, 8'h05, 1, "R5 single read");

    // R2 foreign address
    i2cStart();
    sendByte(8'hE6, 1'b0, ack);
    chk("R2 foreign address nack", 128'(ack), 128'd0);
    sendByte(8'h05, 1'b0, ack);
    chk("R2 foreign transfer ignored", 128'(ack), 128'd0);
    sendByte(8'h11, 1'b0, ack);
    i2cStop();
    chk("R2 no write on foreign address", ctrlRegs, expFlat());

    // R4 wrap through read-only slot 15
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    doWrite(8'h0E, 4, -1);
    chk("R4 burst wrap", ctrlRegs, expFlat());

    // R5 burst read then NACK keeps pointer
    doRead(1'b1, 8'h0D, 3, "R5 burst read");
    doRead(1'b0, 8'h00, 1, "R5 NACK keeps pointer");

    // R6 read-only windows
    doRead(1'b1, 8'h03, 1, "R6 ifcount read");
    wbuf[0] = 8'hFF;
    doWrite(8'h03, 1, -1);
    chk("R6 write to read-only ignored", ctrlRegs, expFlat());
    doRead(1'b1, 8'h03, 1, "R6 ifcount after write");
    doRead(1'b1, 8'h0F, 1, "R6 rssi read");

    // R7 self-clearing start bit
    wbuf[0] = 8'hFF;
    doWrite(8'h01, 1, -1);
    @(negedge clk); measDoneIn = 1'b1;
    @(negedge clk); measDoneIn = 1'b0;
    repeat (2) @(negedge clk);
    model[1][1] = 1'b0;
    chk("R7 self clear", 128'(ctrlRegs[15:8]), 128'h FD);

    // R8 write and clear in the same cycle
    wbuf[0] = 8'h02;
    doWrite(8'h01, 1, 0);
    repeat (2) @(negedge clk);
    chk("R8 write wins over clear", 128'(ctrlRegs[15:8]), 128'h02);

    // R9 STOP inside a data byte
    i2cStart();
    sendByte(ADDR_W, 1'b0, ack);
    sendByte(8'h07, 1'b0, ack);
    sendBits(8'hFF, 4);
    i2cStop();
    chk("R9 stop abort no write", ctrlRegs, expFlat());
    chk("R9 SDA released after stop", 128'(sdaOe), 128'd0);

    // R9 repeated START inside a data byte
    i2cStart();
    sendByte(ADDR_W, 1'b0, ack);
    sendByte(8'h08, 1'b0, ack);
    sendBits(8'h00, 5);
    wbuf[0] = 8'h6B;
    doWrite(8'h08, 1, -1);
    chk("R9 start abort then write", ctrlRegs, expFlat());

    // random bursts
    for (int it = 0; it < 24; it++) begin
      ifCountIn = 8'($urandom);
      rssiIn = 8'($urandom);
      n = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      rb = 8'($urandom);
      doWrite(rb, n, -1);
      chk("R4 random burst write", ctrlRegs, expFlat());
      n = 1 + int'($urandom % 4);
      rb = 8'($urandom);
      doRead(1'b1, rb, n, "R5 random burst read");
    end

    chk("R10 drive changes with SCL high", 128'(oeFlips), 128'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule